// File: doc/BRIEF.md
# Programmable Flag I/O Controller

This block runs a bank of general-purpose pins through a small register interface. Software sets the direction of each pin. It can drive output levels with write-one-to-act set, clear and toggle ports, or with a direct load of every level at once. A read returns the level seen on every pin. Because all modifications are write-one-to-act, any subset of pins can change in a single write, with no read-modify-write.

Each pin can raise an interrupt. Its sensitivity is chosen per pin: level, rising edge, or both edges. Input pins are resynchronised before their level is read back or checked for edges. The interrupt source for an output pin is the value that software drives, so a software change to an output can raise an interrupt.

Edge events stay pending until software writes a one to the matching bit of the pending port. A level-sensitive pin is not latched and requests an interrupt only while it is high. The pins form equal groups, and each group drives one interrupt output. That output is the OR of the enabled, active bits of the group.

Top module: `pflag_gpio`

## Requirements
- R1: After reset every pin is an input (pin_oe_o all 0), all interrupt enables are 0, every pin is level sensitive, nothing is pending, the output levels are 0 and irq_o is 0.
- R2: Register address 4h4 holds the direction bits, with bit n for pin n and 1 meaning output. pin_oe_o equals this register from the clock edge after a write to it, and a read of address 4h4 returns it.
- R3: A write to address 4h1 sets, 4h2 clears and 4h3 inverts the output level of every pin whose write bit is 1. Pins whose write bit is 0 keep their level. pin_o shows the result after the write edge.
- R4: A write to address 4h0 loads all output levels. A read of 4h0 returns the sense of each pin: the driven level for an output pin, and for an input pin its input resynchronised through two flops. The read therefore shows a change at pin_i after two clock edges and not after one.
- R5: A write of ones to address 4h5 enables those pins' interrupts, and a write of ones to 4h6 disables them. Other enable bits are unchanged, and a read of 4h5 returns the enable mask.
- R6: A level-sensitive pin (bit 0 in the register at 4h7) is active only while its sense is 1. Its request follows the pin and is not latched.
- R7: An edge-sensitive pin (bit 1 at 4h7) whose bit at 4h8 is 0 latches a pending event on a rising sense edge. A falling edge is ignored, and the pending bit holds after the pin returns low. For an input pin, irq_o rises on the third clock edge after pin_i rises.
- R8: An edge-sensitive pin whose bit at 4h8 is 1 latches a pending event on both the rising and the falling edge.
- R9: A write of ones to address 4h9 clears those pending edge bits, and bits written as 0 stay pending. A read of 4h9 returns the active vector: latched events for edge pins and the current sense for level pins.
- R10: irq_o[g] is the OR of the enabled active bits of pins g*8 to g*8+7. A pin that is active but disabled stays visible at 4h9 and raises no interrupt.
- R11: An output pin in edge mode raises an interrupt when a software write changes its driven level in the selected direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for read and write |
| reg_wdata_i | input | N_PINS | Write data, one bit per pin |
| reg_rdata_o | output | N_PINS | Read data, combinational from reg_addr_i |
| pin_i | input | N_PINS | Pin levels from the pads |
| pin_o | output | N_PINS | Driven output levels |
| pin_oe_o | output | N_PINS | Output enables (direction) |
| irq_o | output | N_GROUPS | One interrupt request per pin group |

## Verification
The bench builds the block with N_PINS = 16 and N_GROUPS = 2, so each group has eight pins. With these values, one test sequence can use output pins in the low group and input pins in the high group. It can then drive both interrupt outputs separately, and at the end together. The 16-bit vectors keep each expected readback a short hex constant. These combine level pins and edge pins, and pins driven by software and by the pads, in a single read.

// File: rtl/pflag_gpio_pkg.sv
package pflag_gpio_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_FLAG    = 4'h0,
    A_SET     = 4'h1,
    A_CLR     = 4'h2,
    A_TGL     = 4'h3,
    A_DIR     = 4'h4,
    A_IEN_SET = 4'h5,
    A_IEN_CLR = 4'h6,
    A_EDGE    = 4'h7,
    A_BOTH    = 4'h8,
    A_PEND    = 4'h9
  } reg_addr_e;
endpackage

// File: rtl/pflag_gpio_sync.sv
module pflag_gpio_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pflag_gpio_pend.sv
module pflag_gpio_pend #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, pend_q, ev;

  assign ev = (sense_i & ~prev_q) | (~sense_i & prev_q & both_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= sense_i;
      // a new event wins over a same-cycle clear; level pins never hold state
      pend_q <= ((pend_q & ~clr_i) | ev) & edge_i;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pflag_gpio_irq.sv
module pflag_gpio_irq #(
  parameter int unsigned N_PINS   = 16,
  parameter int unsigned N_GROUPS = 2
) (
  input  logic [N_PINS-1:0]   act_i,
  output logic [N_GROUPS-1:0] irq_o
);
  localparam int unsigned GRP_W = N_PINS / N_GROUPS;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign irq_o[g] = |act_i[g*GRP_W +: GRP_W];
  end
endmodule

// File: rtl/pflag_gpio.sv
module pflag_gpio
  import pflag_gpio_pkg::*;
#(
  parameter int unsigned N_PINS   = 16,
  parameter int unsigned N_GROUPS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [N_PINS-1:0]   reg_wdata_i,
  output logic [N_PINS-1:0]   reg_rdata_o,
  input  logic [N_PINS-1:0]   pin_i,
  output logic [N_PINS-1:0]   pin_o,
  output logic [N_PINS-1:0]   pin_oe_o,
  output logic [N_GROUPS-1:0] irq_o
);
  reg_addr_e   addr_e;
  logic [N_PINS-1:0] out_q, dir_q, ien_q, edge_q, both_q;
  logic [N_PINS-1:0] pin_s, sense, pend_q, active, clr;

  assign addr_e = reg_addr_e'(reg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
    end else if (reg_we_i) begin
      case (addr_e)
        A_FLAG:    out_q  <= reg_wdata_i;
        A_SET:     out_q  <= out_q | reg_wdata_i;
        A_CLR:     out_q  <= out_q & ~reg_wdata_i;
        A_TGL:     out_q  <= out_q ^ reg_wdata_i;
        A_DIR:     dir_q  <= reg_wdata_i;
        A_IEN_SET: ien_q  <= ien_q | reg_wdata_i;
        A_IEN_CLR: ien_q  <= ien_q & ~reg_wdata_i;
        A_EDGE:    edge_q <= reg_wdata_i;
        A_BOTH:    both_q <= reg_wdata_i;
        default:   ;
      endcase
    end
  end

  pflag_gpio_sync #(.W(N_PINS), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  // outputs source their own interrupt from the driven value
  assign sense = (dir_q & out_q) | (~dir_q & pin_s);
  assign clr   = (reg_we_i && addr_e == A_PEND) ? reg_wdata_i : '0;

  pflag_gpio_pend #(.W(N_PINS)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sense_i (sense),
    .edge_i  (edge_q),
    .both_i  (both_q),
    .clr_i   (clr),
    .pend_o  (pend_q)
  );

  assign active = (pend_q & edge_q) | (sense & ~edge_q);

  pflag_gpio_irq #(.N_PINS(N_PINS), .N_GROUPS(N_GROUPS)) u_irq (
    .act_i (active & ien_q),
    .irq_o (irq_o)
  );

  always_comb begin
    case (addr_e)
      A_FLAG:    reg_rdata_o = sense;
      A_DIR:     reg_rdata_o = dir_q;
      A_IEN_SET: reg_rdata_o = ien_q;
      A_EDGE:    reg_rdata_o = edge_q;
      A_BOTH:    reg_rdata_o = both_q;
      A_PEND:    reg_rdata_o = active;
      default:   reg_rdata_o = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
endmodule

// File: rtl/pflag_gpio_chk.sv
module pflag_gpio_chk
  import pflag_gpio_pkg::*;
#(
  parameter int unsigned N_PINS   = 16,
  parameter int unsigned N_GROUPS = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [N_PINS-1:0]   reg_wdata_i,
  input logic [N_PINS-1:0]   pin_o,
  input logic [N_PINS-1:0]   pin_oe_o,
  input logic [N_GROUPS-1:0] irq_o,
  input logic [N_PINS-1:0]   ien_q,
  input logic [N_PINS-1:0]   edge_q,
  input logic [N_PINS-1:0]   pend_q
);
  assert_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_SET) |=> ((pin_o & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  assert_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_CLR) |=> ((pin_o & $past(reg_wdata_i)) == '0));

  assert_tgl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_TGL) |=> (pin_o == ($past(pin_o) ^ $past(reg_wdata_i))));

  assert_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_DIR) |=> (pin_oe_o == $past(reg_wdata_i)));

  assert_ien_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_IEN_SET) |=> ((ien_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  assert_ien_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_IEN_CLR) |=> ((ien_q & $past(reg_wdata_i)) == '0));

  assert_irq_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> (irq_o == '0));

  assert_pend_edge_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(edge_q)) == '0));
endmodule

bind pflag_gpio pflag_gpio_chk #(.N_PINS(N_PINS), .N_GROUPS(N_GROUPS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .pin_o       (pin_o),
  .pin_oe_o    (pin_oe_o),
  .irq_o       (irq_o),
  .ien_q       (ien_q),
  .edge_q      (edge_q),
  .pend_q      (pend_q)
);

// File: tb/pflag_gpio_tb.sv
module pflag_gpio_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;  // 0 read, 1 irq, 2 pin_o, 3 pin_oe
    logic [15:0] val;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  pflag_gpio u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .pin_i       (pin_in),
    .pin_o       (pin_out),
    .pin_oe_o    (pin_oe),
    .irq_o       (irq)
  );

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic expect_v(input int kind, input logic [3:0] a, input logic [15:0] v, input string tag);
    item_t it;
    @(negedge clk);
    if (kind == 0) addr = a;
    it.kind = kind; it.val = v; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expectations and compares one step after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          0:       act = rdata;
          1:       act = {14'b0, irq};
          2:       act = pin_out;
          default: act = pin_oe;
        endcase
        checks++;
        if (act !== it.val) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.val);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_v(3, 4'h0, 16'h0000, "R1 oe");
    expect_v(1, 4'h0, 16'h0000, "R1 irq");
    expect_v(0, 4'h4, 16'h0000, "R1 dir");
    expect_v(0, 4'h5, 16'h0000, "R1 ien");
    expect_v(0, 4'h7, 16'h0000, "R1 edge");
    expect_v(0, 4'h9, 16'h0000, "R1 pend");
    expect_v(2, 4'h0, 16'h0000, "R1 out");
    // R2 direction
    wr(4'h4, 16'h00FF);
    expect_v(3, 4'h0, 16'h00FF, "R2 oe");
    expect_v(0, 4'h4, 16'h00FF, "R2 dir read");
    // R4 direct load
    wr(4'h0, 16'h0005);
    expect_v(2, 4'h0, 16'h0005, "R4 load");
    expect_v(0, 4'h0, 16'h0005, "R4 sense");
    // R3 set/clear/toggle
    wr(4'h1, 16'h00A0);
    expect_v(2, 4'h0, 16'h00A5, "R3 set");
    wr(4'h2, 16'h0004);
    expect_v(2, 4'h0, 16'h00A1, "R3 clear");
    wr(4'h3, 16'h0003);
    expect_v(2, 4'h0, 16'h00A2, "R3 toggle");
    wr(4'h1, 16'h0000);
    expect_v(2, 4'h0, 16'h00A2, "R3 zero write");
    // R4 input resync latency
    @(negedge clk); pin_in = 16'h3C00;
    expect_v(0, 4'h0, 16'h00A2, "R4 one edge");
    expect_v(0, 4'h0, 16'h3CA2, "R4 two edges");
    // R6 level
    expect_v(1, 4'h0, 16'h0000, "R10 masked");
    wr(4'h5, 16'h0400);
    expect_v(1, 4'h0, 16'h0002, "R6 level irq");
    expect_v(0, 4'h9, 16'h3CA2, "R9 level active read");
    expect_v(0, 4'h5, 16'h0400, "R5 ien read");
    @(negedge clk); pin_in = 16'h3800;
    expect_v(1, 4'h0, 16'h0002, "R6 before sync");
    expect_v(1, 4'h0, 16'h0000, "R6 follows pin");
    wr(4'h6, 16'h0400);
    expect_v(0, 4'h5, 16'h0000, "R5 ien clear");
    // R7 rising edge
    wr(4'h7, 16'h0200);
    wr(4'h5, 16'h0200);
    @(negedge clk); pin_in = 16'h3A00;
    expect_v(1, 4'h0, 16'h0000, "R7 edge1");
    expect_v(1, 4'h0, 16'h0000, "R7 edge2");
    expect_v(1, 4'h0, 16'h0002, "R7 edge3");
    @(negedge clk); pin_in = 16'h3800;
    idle(4);
    expect_v(1, 4'h0, 16'h0002, "R7 sticky");
    expect_v(0, 4'h9, 16'h3AA2, "R7 pend read");
    // R9 write-one-to-clear
    wr(4'h9, 16'h0000);
    expect_v(1, 4'h0, 16'h0002, "R9 zero keeps");
    wr(4'h9, 16'h0200);
    expect_v(1, 4'h0, 16'h0000, "R9 cleared");
    expect_v(0, 4'h9, 16'h38A2, "R9 pend after clear");
    // R7 falling ignored
    @(negedge clk); pin_in = 16'h3A00;
    idle(4);
    wr(4'h9, 16'h0200);
    @(negedge clk); pin_in = 16'h3800;
    idle(4);
    expect_v(1, 4'h0, 16'h0000, "R7 fall ignored");
    // R8 both edges
    wr(4'h8, 16'h0200);
    @(negedge clk); pin_in = 16'h3A00;
    idle(4);
    wr(4'h9, 16'h0200);
    expect_v(1, 4'h0, 16'h0000, "R8 cleared");
    @(negedge clk); pin_in = 16'h3800;
    idle(4);
    expect_v(1, 4'h0, 16'h0002, "R8 fall latched");
    wr(4'h9, 16'h0200);
    // R11 output pin interrupt
    wr(4'h7, 16'h0202);
    wr(4'h5, 16'h0002);
    expect_v(1, 4'h0, 16'h0000, "R11 no event");
    wr(4'h2, 16'h0002);
    expect_v(1, 4'h0, 16'h0000, "R11 fall ignored");
    wr(4'h1, 16'h0002);
    expect_v(1, 4'h0, 16'h0001, "R11 rise group0");
    // R10 groups
    @(negedge clk); pin_in = 16'h3A00;
    idle(4);
    expect_v(1, 4'h0, 16'h0003, "R10 both groups");
    wr(4'h6, 16'h0200);
    expect_v(1, 4'h0, 16'h0001, "R10 disabled");
    expect_v(0, 4'h9, 16'h3AA2, "R10 still pending");
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule